// File: doc/BRIEF.md
# Dual-Bank Tightly Coupled RAM Arbiter

This block sits in front of a 32 KB on-chip RAM built as two independent 16 KB banks. Three masters share it: an instruction-fetch port that only reads, a data port that reads and writes, and a DMA port that other bus masters use. The fetch port sees the RAM at byte addresses 0x0000 to 0x7FFF. The data port sees the same physical words at 0x10000 to 0x17FFF. The DMA port may use either window. Bit 14 of the offset inside a window picks the bank.

Each cycle, every bank serves at most one port. A fetch and a data access that land in different banks go through together. On the same bank the data port wins. The DMA port has the lowest priority, but it takes the bank after two lost cycles in a row. An address outside a port's windows is accepted at once and answered with an error. It uses no bank and writes nothing.

Requests use valid/ready. A master raises valid with a stable request and holds it until it sees ready at a clock edge. Ready is meaningful only while valid is high. Responses cannot be stalled: every accepted request gets exactly one response pulse in the next cycle, and the master must take it.

Top module: `dbank_tcm_arbiter`

## Requirements
- R1: On the fetch port, addresses 0x0000–0x7FFF reach the RAM at offset equal to the address. Any other fetch address, including the data window, is out of window.
- R2: On the data port, addresses 0x10000–0x17FFF reach the same physical RAM at offset address minus 0x10000. A word written through the data port reads back through the fetch port at the same offset.
- R3: The DMA port accepts both windows, each with its own offset rule, and reaches the same words as the other two ports.
- R4: The bank is offset bit 14. Fetch and data requests to different banks are both accepted in the same cycle.
- R5: When fetch and data request the same bank, data is accepted and fetch is held not ready. Fetch is accepted in the next cycle once the conflict has cleared.
- R6: A DMA request that shares a bank with a fetch or data request loses, unless it is already owed the bank under R7.
- R7: After a DMA request has lost two consecutive cycles, it is accepted in the third, ahead of fetch and data.
- R8: Each accepted request gives exactly one rsp_valid pulse in the cycle right after acceptance. There are no other pulses. A read returns the addressed word as it was before that cycle.
- R9: A write updates byte k (bits 8k+7:8k) only when byte-enable bit k is 1.
- R10: An out-of-window request is ready in the cycle it is presented. Its response carries err=1 and data zero, and no RAM word changes.
- R11: A write response carries err=0 and data zero.
- R12: While reset is asserted, all three rsp_valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| if_valid | input | 1 | Fetch request valid |
| if_ready | output | 1 | Fetch request accepted this edge |
| if_addr | input | 32 | Fetch byte address |
| if_rsp_valid | output | 1 | Fetch response pulse |
| if_rsp_data | output | 32 | Fetch read data |
| if_rsp_err | output | 1 | Fetch address out of window |
| dp_valid | input | 1 | Data request valid |
| dp_ready | output | 1 | Data request accepted this edge |
| dp_addr | input | 32 | Data byte address |
| dp_write | input | 1 | Data request is a write |
| dp_byte_en | input | 4 | Data write byte enables |
| dp_wdata | input | 32 | Data write word |
| dp_rsp_valid | output | 1 | Data response pulse |
| dp_rsp_data | output | 32 | Data read data |
| dp_rsp_err | output | 1 | Data address out of window |
| dm_valid | input | 1 | DMA request valid |
| dm_ready | output | 1 | DMA request accepted this edge |
| dm_addr | input | 32 | DMA byte address |
| dm_write | input | 1 | DMA request is a write |
| dm_byte_en | input | 4 | DMA write byte enables |
| dm_wdata | input | 32 | DMA write word |
| dm_rsp_valid | output | 1 | DMA response pulse |
| dm_rsp_data | output | 32 | DMA read data |
| dm_rsp_err | output | 1 | DMA address out of window |

## Verification
The assertions check the following on every cycle:
- at most one port wins each bank, and a bank with a request is never left idle;
- fetch and data run in parallel on split banks, and data wins a shared bank;
- DMA yields while not owed the bank, and never waits more than two cycles;
- every acceptance gives exactly one response a cycle later;
- error and write responses carry zero data.

Only the bench's scenarios can show the things that depend on RAM contents: the aliasing of the two windows onto the same words, byte-enable merging, and an out-of-window write leaving memory untouched. The bench checks these through a shadow model, which also checks the exact response cycle and data for every request.

// File: rtl/dtcm_pkg.sv
package dtcm_pkg;
  localparam int unsigned NPORT = 3;
  localparam int unsigned NBANK = 2;

  typedef enum logic [1:0] {
    PORT_FETCH = 2'd0,
    PORT_DATA  = 2'd1,
    PORT_DMA   = 2'd2
  } port_e;

  // Port index owning a bank, given that bank's one-hot grant.
  function automatic port_e owner(input logic [NPORT-1:0] gnt);
    if (gnt[PORT_DMA])       return PORT_DMA;
    else if (gnt[PORT_DATA]) return PORT_DATA;
    else                     return PORT_FETCH;
  endfunction
endpackage

// File: rtl/dtcm_window_dec.sv
module dtcm_window_dec #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 15,
  parameter int unsigned LSB_W  = 2,
  parameter int unsigned WORD_W = OFF_W - 1 - LSB_W,
  parameter logic [ADDR_W-1:0] FETCH_BASE = '0,
  parameter logic [ADDR_W-1:0] DATA_BASE  = 'h10000,
  parameter bit FETCH_EN = 1'b1,
  parameter bit DATA_EN  = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              bank,
  output logic [WORD_W-1:0] word
);
  logic in_fetch, in_data;
  logic unused_lsb;

  assign in_fetch = FETCH_EN && (addr[ADDR_W-1:OFF_W] == FETCH_BASE[ADDR_W-1:OFF_W]);
  assign in_data  = DATA_EN  && (addr[ADDR_W-1:OFF_W] == DATA_BASE[ADDR_W-1:OFF_W]);
  assign hit      = in_fetch | in_data;
  assign bank     = addr[OFF_W-1];
  assign word     = addr[OFF_W-2:LSB_W];
  assign unused_lsb = ^addr[LSB_W-1:0];
endmodule

// File: rtl/dtcm_bank_arb.sv
module dtcm_bank_arb
  import dtcm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] req,
  input  logic             dma_urgent,
  output logic [NPORT-1:0] gnt
);
  always_comb begin
    gnt = '0;
    if (dma_urgent && req[PORT_DMA]) gnt[PORT_DMA]   = 1'b1;
    else if (req[PORT_DATA])         gnt[PORT_DATA]  = 1'b1;
    else if (req[PORT_FETCH])        gnt[PORT_FETCH] = 1'b1;
    else if (req[PORT_DMA])          gnt[PORT_DMA]   = 1'b1;
  end

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)) else $error("bank granted twice"); // R5
  AST_OWNER_ASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0) else $error("grant without request"); // R4
  AST_NO_IDLE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> (gnt != '0)) else $error("requested bank idle"); // R4
endmodule

// File: rtl/dtcm_bank_ram.sv
module dtcm_bank_ram #(
  parameter int unsigned WORD_W = 12,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned BE_W  = DATA_W / 8,
  localparam int unsigned DEPTH = 1 << WORD_W
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [BE_W-1:0]   be,
  input  logic [WORD_W-1:0] word,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      rdata <= mem[word];
      if (we) begin
        for (int k = 0; k < BE_W; k++) begin
          if (be[k]) mem[word][8*k +: 8] <= wdata[8*k +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/dbank_tcm_arbiter.sv
module dbank_tcm_arbiter
  import dtcm_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned RAM_BYTES = 32768,
  parameter logic [ADDR_W-1:0] DATA_BASE = 'h10000,
  parameter int unsigned MAX_LOSS  = 2,
  localparam int unsigned BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_valid,
  output logic              if_ready,
  input  logic [ADDR_W-1:0] if_addr,
  output logic              if_rsp_valid,
  output logic [DATA_W-1:0] if_rsp_data,
  output logic              if_rsp_err,
  input  logic              dp_valid,
  output logic              dp_ready,
  input  logic [ADDR_W-1:0] dp_addr,
  input  logic              dp_write,
  input  logic [BE_W-1:0]   dp_byte_en,
  input  logic [DATA_W-1:0] dp_wdata,
  output logic              dp_rsp_valid,
  output logic [DATA_W-1:0] dp_rsp_data,
  output logic              dp_rsp_err,
  input  logic              dm_valid,
  output logic              dm_ready,
  input  logic [ADDR_W-1:0] dm_addr,
  input  logic              dm_write,
  input  logic [BE_W-1:0]   dm_byte_en,
  input  logic [DATA_W-1:0] dm_wdata,
  output logic              dm_rsp_valid,
  output logic [DATA_W-1:0] dm_rsp_data,
  output logic              dm_rsp_err
);
  localparam int unsigned OFF_W  = $clog2(RAM_BYTES);
  localparam int unsigned LSB_W  = $clog2(BE_W);
  localparam int unsigned WORD_W = OFF_W - 1 - LSB_W;
  localparam int unsigned LOSS_W = $clog2(MAX_LOSS + 2);
  localparam logic [LOSS_W-1:0] LOSS_LIM = LOSS_W'(MAX_LOSS);

  // Gather the three ports into indexed arrays.
  logic [NPORT-1:0]  p_valid, p_write, p_hit, p_bank, p_ready;
  logic [ADDR_W-1:0] p_addr  [NPORT];
  logic [BE_W-1:0]   p_be    [NPORT];
  logic [DATA_W-1:0] p_wdata [NPORT];
  logic [WORD_W-1:0] p_word  [NPORT];

  assign p_valid = {dm_valid, dp_valid, if_valid};
  assign p_write = {dm_write, dp_write, 1'b0};
  assign p_addr[PORT_FETCH]  = if_addr;
  assign p_addr[PORT_DATA]   = dp_addr;
  assign p_addr[PORT_DMA]    = dm_addr;
  assign p_be[PORT_FETCH]    = '0;
  assign p_be[PORT_DATA]     = dp_byte_en;
  assign p_be[PORT_DMA]      = dm_byte_en;
  assign p_wdata[PORT_FETCH] = '0;
  assign p_wdata[PORT_DATA]  = dp_wdata;
  assign p_wdata[PORT_DMA]   = dm_wdata;

  for (genvar p = 0; p < NPORT; p++) begin : g_dec
    dtcm_window_dec #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LSB_W(LSB_W), .WORD_W(WORD_W),
      .FETCH_BASE('0), .DATA_BASE(DATA_BASE),
      .FETCH_EN(p != int'(PORT_DATA)), .DATA_EN(p != int'(PORT_FETCH))
    ) u_dec (
      .addr(p_addr[p]), .hit(p_hit[p]), .bank(p_bank[p]), .word(p_word[p])
    );
  end

  // DMA aging: consecutive cycles the DMA request was presented and refused.
  logic [LOSS_W-1:0] dma_loss;
  logic              dma_urgent;
  assign dma_urgent = (dma_loss >= LOSS_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   dma_loss <= '0;
    else if (p_valid[PORT_DMA] && !p_ready[PORT_DMA])
      dma_loss <= dma_urgent ? dma_loss : dma_loss + 1'b1;
    else                                          dma_loss <= '0;
  end

  // Per-bank arbitration and storage.
  logic [NPORT-1:0]  breq   [NBANK];
  logic [NPORT-1:0]  bgnt   [NBANK];
  logic [DATA_W-1:0] brdata [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    port_e             sel;
    logic              b_en, b_we;
    logic [BE_W-1:0]   b_be;
    logic [WORD_W-1:0] b_word;
    logic [DATA_W-1:0] b_wdata;

    always_comb begin
      for (int p = 0; p < NPORT; p++)
        breq[b][p] = p_valid[p] & p_hit[p] & (p_bank[p] == 1'(b));
    end

    dtcm_bank_arb u_arb (
      .clk(clk), .rst_n(rst_n), .req(breq[b]),
      .dma_urgent(dma_urgent), .gnt(bgnt[b])
    );

    assign sel     = owner(bgnt[b]);
    assign b_en    = |bgnt[b];
    assign b_we    = p_write[sel];
    assign b_be    = p_be[sel];
    assign b_word  = p_word[sel];
    assign b_wdata = p_wdata[sel];

    dtcm_bank_ram #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_ram (
      .clk(clk), .en(b_en), .we(b_we), .be(b_be),
      .word(b_word), .wdata(b_wdata), .rdata(brdata[b])
    );
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++)
      p_ready[p] = !p_hit[p] || bgnt[p_bank[p]][p];
  end

  assign if_ready = p_ready[PORT_FETCH];
  assign dp_ready = p_ready[PORT_DATA];
  assign dm_ready = p_ready[PORT_DMA];

  // Fixed one-cycle response stage.
  logic [NPORT-1:0]  rsp_v_q, rsp_err_q, rsp_rd_q, rsp_bank_q;
  logic [DATA_W-1:0] rsp_data [NPORT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q    <= '0;
      rsp_err_q  <= '0;
      rsp_rd_q   <= '0;
      rsp_bank_q <= '0;
    end else begin
      rsp_v_q    <= p_valid & p_ready;
      rsp_err_q  <= ~p_hit;
      rsp_rd_q   <= p_hit & ~p_write;
      rsp_bank_q <= p_bank;
    end
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++)
      rsp_data[p] = (rsp_v_q[p] && rsp_rd_q[p]) ? brdata[rsp_bank_q[p]] : '0;
  end

  assign if_rsp_valid = rsp_v_q[PORT_FETCH];
  assign dp_rsp_valid = rsp_v_q[PORT_DATA];
  assign dm_rsp_valid = rsp_v_q[PORT_DMA];
  assign if_rsp_err   = rsp_v_q[PORT_FETCH] & rsp_err_q[PORT_FETCH];
  assign dp_rsp_err   = rsp_v_q[PORT_DATA]  & rsp_err_q[PORT_DATA];
  assign dm_rsp_err   = rsp_v_q[PORT_DMA]   & rsp_err_q[PORT_DMA];
  assign if_rsp_data  = rsp_data[PORT_FETCH];
  assign dp_rsp_data  = rsp_data[PORT_DATA];
  assign dm_rsp_data  = rsp_data[PORT_DMA];

  // ---------------- assertions ----------------
  logic [LOSS_W:0] dm_wait;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     dm_wait <= '0;
    else if (dm_valid && !dm_ready) dm_wait <= (dm_wait > {1'b0, LOSS_LIM}) ? dm_wait : dm_wait + 1'b1;
    else                            dm_wait <= '0;
  end

  AST_DMA_BOUNDED_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    dm_wait <= {1'b0, LOSS_LIM}) else $error("DMA starved"); // R7
  AST_SPLIT_BANKS_PARALLEL: assert property (@(posedge clk) disable iff (!rst_n)
    (if_valid && dp_valid && p_hit[PORT_FETCH] && p_hit[PORT_DATA] &&
     (p_bank[PORT_FETCH] != p_bank[PORT_DATA]) && !dm_valid) |-> (if_ready && dp_ready))
    else $error("split banks not parallel"); // R4
  AST_DATA_BEATS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (if_valid && dp_valid && p_hit[PORT_FETCH] && p_hit[PORT_DATA] &&
     (p_bank[PORT_FETCH] == p_bank[PORT_DATA]) && !dm_valid) |-> (dp_ready && !if_ready))
    else $error("fetch beat data"); // R5
  AST_DMA_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_valid && p_hit[PORT_DMA] && !dma_urgent &&
     ((dp_valid && p_hit[PORT_DATA] && p_bank[PORT_DATA] == p_bank[PORT_DMA]) ||
      (if_valid && p_hit[PORT_FETCH] && p_bank[PORT_FETCH] == p_bank[PORT_DMA]))) |-> !dm_ready)
    else $error("DMA did not yield"); // R6

  for (genvar p = 0; p < NPORT; p++) begin : g_rsp_chk
    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (p_valid[p] && p_ready[p]) |=> rsp_v_q[p]) else $error("response missing"); // R8
    AST_RSP_ONLY_IF_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
      !(p_valid[p] && p_ready[p]) |=> !rsp_v_q[p]) else $error("stray response"); // R8
    AST_ERR_RSP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (p_valid[p] && !p_hit[p]) |=> (rsp_err_q[p] && rsp_data[p] == '0)) else $error("bad error response"); // R10
    AST_WRITE_RSP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (p_valid[p] && p_ready[p] && p_hit[p] && p_write[p]) |=> (!rsp_err_q[p] && rsp_data[p] == '0))
      else $error("bad write response"); // R11
  end
endmodule

// File: tb/dbank_tcm_arbiter_test.sv
module dbank_tcm_arbiter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [2:0]  v, w;
  logic [31:0] a  [3];
  logic [3:0]  be [3];
  logic [31:0] wd [3];

  logic        if_ready, if_rsp_valid, if_rsp_err;
  logic        dp_ready, dp_rsp_valid, dp_rsp_err;
  logic        dm_ready, dm_rsp_valid, dm_rsp_err;
  logic [31:0] if_rsp_data, dp_rsp_data, dm_rsp_data;

  dbank_tcm_arbiter uut (
    .clk(clk), .rst_n(rst_n),
    .if_valid(v[0]), .if_ready(if_ready), .if_addr(a[0]),
    .if_rsp_valid(if_rsp_valid), .if_rsp_data(if_rsp_data), .if_rsp_err(if_rsp_err),
    .dp_valid(v[1]), .dp_ready(dp_ready), .dp_addr(a[1]), .dp_write(w[1]),
    .dp_byte_en(be[1]), .dp_wdata(wd[1]),
    .dp_rsp_valid(dp_rsp_valid), .dp_rsp_data(dp_rsp_data), .dp_rsp_err(dp_rsp_err),
    .dm_valid(v[2]), .dm_ready(dm_ready), .dm_addr(a[2]), .dm_write(w[2]),
    .dm_byte_en(be[2]), .dm_wdata(wd[2]),
    .dm_rsp_valid(dm_rsp_valid), .dm_rsp_data(dm_rsp_data), .dm_rsp_err(dm_rsp_err)
  );

  typedef struct packed {
    logic [31:0] cyc;
    logic        err;
    logic [31:0] data;
    logic [31:0] tag;
  } exp_t;

  exp_t q0[$], q1[$], q2[$];
  logic [31:0] model [int];
  logic [31:0] cur_tag;
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Window rules from R1, R2, R3: port 0 fetch, 1 data, 2 DMA.
  function automatic void decode(input int p, input logic [31:0] addr,
                                 output logic hit, output int widx);
    hit = 1'b0;
    if (p != 1 && addr < 32'h8000) hit = 1'b1;
    if (p != 0 && addr >= 32'h10000 && addr < 32'h18000) hit = 1'b1;
    widx = int'(addr[14:2]);
  endfunction

  task automatic push(input int p, input exp_t e);
    case (p)
      0: q0.push_back(e);
      1: q1.push_back(e);
      default: q2.push_back(e);
    endcase
  endtask

  // One cycle: sample readiness before the edge, build expectations, cross the edge.
  task automatic tick(output logic [2:0] acc);
    #2;
    acc = {dm_ready, dp_ready, if_ready} & v;
    for (int p = 0; p < 3; p++) begin
      if (acc[p]) begin
        exp_t e;
        logic hit;
        int widx;
        decode(p, a[p], hit, widx);
        e.cyc = cyc + 1;
        e.tag = cur_tag;
        e.err = !hit;
        e.data = '0;
        if (hit && w[p]) begin
          logic [31:0] old;
          old = model.exists(widx) ? model[widx] : 32'h0;
          for (int k = 0; k < 4; k++)
            if (be[p][k]) old[8*k +: 8] = wd[p][8*k +: 8];
          model[widx] = old;
        end else if (hit) begin
          e.data = model[widx];
        end
        push(p, e);
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic mon(input int p, input logic vld, input logic err, input logic [31:0] d);
    exp_t e;
    logic got;
    if (!vld) return;
    got = 1'b0;
    case (p)
      0: if (q0.size() > 0) begin e = q0.pop_front(); got = 1'b1; end
      1: if (q1.size() > 0) begin e = q1.pop_front(); got = 1'b1; end
      default: if (q2.size() > 0) begin e = q2.pop_front(); got = 1'b1; end
    endcase
    n_chk++;
    if (!got) begin
      n_bad++;
      $display("FAIL R8 port %0d stray response actual=%h expected=none", p, d);
    end else if (e.cyc != cyc || e.err != err || e.data != d) begin
      n_bad++;
      $display("FAIL %s/R8 port %0d actual cyc=%0d err=%b data=%h expected cyc=%0d err=%b data=%h",
               e.tag, p, cyc, err, d, e.cyc, e.err, e.data);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      mon(0, if_rsp_valid, if_rsp_err, if_rsp_data);
      mon(1, dp_rsp_valid, dp_rsp_err, dp_rsp_data);
      mon(2, dm_rsp_valid, dm_rsp_err, dm_rsp_data);
    end
  end

  // Single-port request held until accepted; returns cycles taken.
  task automatic solo(input int p, input logic [31:0] addr, input logic wr,
                      input logic [3:0] bmask, input logic [31:0] data, output int n);
    logic [2:0] acc;
    a[p] = addr; w[p] = wr; be[p] = bmask; wd[p] = data; v[p] = 1'b1;
    n = 0;
    do begin tick(acc); n++; end while (!acc[p] && n < 8);
    v[p] = 1'b0; w[p] = 1'b0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [2:0] acc;
    int n;
    v = '0; w = '0;
    for (int p = 0; p < 3; p++) begin a[p] = '0; be[p] = '0; wd[p] = '0; end
    cur_tag = "R12";
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: quiet during reset
    chk(!if_rsp_valid && !dp_rsp_valid && !dm_rsp_valid, "R12",
        {if_rsp_valid, dp_rsp_valid, dm_rsp_valid}, 0);
    rst_n = 1'b1;
    tick(acc);

    // R2 / R11: fill words through the data window (write responses zero)
    cur_tag = "R2";
    solo(1, 32'h10000, 1'b1, 4'hF, 32'hA5A5_0001, n);
    solo(1, 32'h14000, 1'b1, 4'hF, 32'hB6B6_0002, n);
    solo(1, 32'h14010, 1'b1, 4'hF, 32'hC7C7_0003, n);
    solo(1, 32'h10004, 1'b1, 4'hF, 32'h0BAD_F00D, n);
    solo(1, 32'h14010, 1'b0, 4'h0, 32'h0, n);
    // R1: fetch window aliases the same words
    cur_tag = "R1";
    solo(0, 32'h00000, 1'b0, 4'h0, 32'h0, n);
    solo(0, 32'h04010, 1'b0, 4'h0, 32'h0, n);
    solo(0, 32'h04000, 1'b0, 4'h0, 32'h0, n);

    // R3: DMA writes via fetch window, reads via data window and back
    cur_tag = "R3";
    solo(2, 32'h00020, 1'b1, 4'hF, 32'hFFFF_FFFF, n);
    solo(1, 32'h10020, 1'b0, 4'h0, 32'h0, n);
    solo(2, 32'h10000, 1'b0, 4'h0, 32'h0, n);

    // R9: partial write with byte enables 0101
    cur_tag = "R9";
    solo(1, 32'h10020, 1'b1, 4'b0101, 32'h1122_3344, n);
    solo(2, 32'h00020, 1'b0, 4'h0, 32'h0, n);

    // R10: out-of-window requests accepted at once, error, no write
    cur_tag = "R10";
    solo(1, 32'h08000, 1'b0, 4'h0, 32'h0, n);
    chk(n == 1, "R10 ready at once", n, 1);
    solo(1, 32'h18004, 1'b1, 4'hF, 32'hDEAD_DEAD, n);
    chk(n == 1, "R10 ready at once", n, 1);
    solo(0, 32'h10000, 1'b0, 4'h0, 32'h0, n);
    chk(n == 1, "R10 fetch rejects data window", n, 1);
    solo(2, 32'h20000, 1'b0, 4'h0, 32'h0, n);
    solo(1, 32'h10004, 1'b0, 4'h0, 32'h0, n);

    // R4: fetch bank 0, data bank 1, same cycle
    cur_tag = "R4";
    a[0] = 32'h00000; v[0] = 1'b1;
    a[1] = 32'h14010; w[1] = 1'b0; v[1] = 1'b1;
    tick(acc);
    chk(acc == 3'b011, "R4 parallel banks", acc, 3'b011);
    v = '0;

    // R5: same bank, data first, fetch next cycle
    cur_tag = "R5";
    a[0] = 32'h04010; v[0] = 1'b1;
    a[1] = 32'h14000; v[1] = 1'b1;
    tick(acc);
    chk(acc == 3'b010, "R5 data wins", acc, 3'b010);
    v[1] = 1'b0;
    tick(acc);
    chk(acc == 3'b001, "R5 fetch next", acc, 3'b001);
    v = '0;

    // R6: DMA loses to fetch on the same bank
    cur_tag = "R6";
    a[0] = 32'h00000; v[0] = 1'b1;
    a[2] = 32'h00020; w[2] = 1'b0; v[2] = 1'b1;
    tick(acc);
    chk(acc == 3'b001, "R6 DMA yields", acc, 3'b001);
    v[0] = 1'b0;
    tick(acc);
    chk(acc == 3'b100, "R6 DMA after", acc, 3'b100);
    v = '0;

    // R7: DMA taken on the third cycle despite steady data traffic
    cur_tag = "R7";
    a[1] = 32'h10000; v[1] = 1'b1;
    a[2] = 32'h00020; v[2] = 1'b1;
    tick(acc);
    chk(acc == 3'b010, "R7 first loss", acc, 3'b010);
    a[1] = 32'h10004;
    tick(acc);
    chk(acc == 3'b010, "R7 second loss", acc, 3'b010);
    a[1] = 32'h10020;
    tick(acc);
    chk(acc == 3'b100, "R7 DMA owed bank", acc, 3'b100);
    v[2] = 1'b0;
    tick(acc);
    chk(acc == 3'b010, "R7 data resumes", acc, 3'b010);
    v = '0;

    // R8: no responses left owed
    cur_tag = "R8";
    repeat (3) tick(acc);
    chk(q0.size() == 0 && q1.size() == 0 && q2.size() == 0, "R8 all answered",
        q0.size() + q1.size() + q2.size(), 0);
    summary();
    $finish;
  end
endmodule